// File: doc/BRIEF.md
# Camera Packet Parser with Early Termination

This block sits behind the lane-merging layer of a serial camera receiver. Each transmission burst arrives as a run of 32-bit words. The first word of a burst is the packet header and the last word is flagged. The parser decodes the header and sorts the packet into one of three kinds. A short packet appears on a single-cycle side output. A long packet has its payload streamed out as byte-masked beats that carry start and end markers, and its trailing two-byte checksum is reported on a separate port. Null and blanking packets are thrown away without any trace.

Packets from different virtual channels and with different data types can follow one another in any order. Every beat carries the channel and type of the packet it belongs to, so a downstream demultiplexer needs no other state. A long packet can be cut short by three conditions: a soft reset request, the block being disabled, or the downstream line buffer reporting full. In that case the parser emits a closing empty beat that carries the end marker. For embedded non-image data, that closing beat also carries an abort flag. The parser then ignores the rest of the burst. A burst that ends before its payload is complete is closed the same way.

Top module: `csi_pkt_parser`

## Requirements
- R1: The first word of a burst is a header. Bits [5:0] are the data type, bits [7:6] the virtual channel, bits [23:8] the word count (byte 1 holds the low half), and bits [31:24] are ignored.
- R2: A header whose data type is 0x00 to 0x0F raises `sp_valid` for exactly one cycle, one cycle after the header word. It presents the channel, the type and the 16-bit word-count field as `sp_value`, and it produces no stream beat.
- R3: A long packet with word count N sends its N payload bytes in order. Payload byte k sits on lane k mod 4 (bits [8*lane+7:8*lane]) of the k/4-th beat. Each beat follows its input word by one cycle. Only the valid bytes have their `st_keep` bits set, and the other bytes read as zero. The first beat has `st_first`, and the beat holding byte N-1 has `st_last`.
- R4: A long packet with word count 0 produces no stream beat.
- R5: The two bytes that follow the payload form the checksum, low byte first. `cs_valid` pulses with `cs_value` one cycle after the word that holds the second checksum byte.
- R6: Data types 0x10 (null) and 0x11 (blanking) produce nothing on any output, and the next burst is parsed normally.
- R7: Consecutive packets may use any mix of virtual channels and data types. Each beat and each short-packet report carries the fields of its own header.
- R8: If `lb_full`, a low `enable` or `soft_rst` is seen in a cycle while payload bytes are still owed, the word offered in that cycle is dropped. One cycle later a beat appears with `st_keep`=0, zero data and `st_last`=1. That beat also has `st_first` set if no beat of the packet was sent yet. `st_abort` is set on it only when the data type is 0x12.
- R9: After a termination, the words that remain in the burst are discarded, and the next burst is parsed normally.
- R10: A termination condition that arrives after the last payload byte was sent, but before the checksum is complete, produces no beat and no checksum report.
- R11: A header offered while `enable` is low or `soft_rst` is high is discarded together with the rest of its burst.
- R12: While `rst` is high and on the cycle after it, `st_valid`, `sp_valid` and `cs_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Parser enable; low terminates or discards |
| soft_rst | input | 1 | Soft reset request; terminates or discards |
| lb_full | input | 1 | Downstream line buffer full |
| in_valid | input | 1 | Input word valid |
| in_data | input | 8*NB | Merged lane word, byte 0 in bits [7:0] |
| in_last | input | 1 | Last word of the burst |
| st_valid | output | 1 | Payload beat valid |
| st_data | output | 8*NB | Payload bytes, masked bytes zero |
| st_keep | output | NB | Byte-valid mask |
| st_first | output | 1 | First beat of a packet |
| st_last | output | 1 | Last beat of a packet (end of line) |
| st_abort | output | 1 | Early termination of embedded data |
| st_vc | output | 2 | Virtual channel of the beat |
| st_dt | output | 6 | Data type of the beat |
| sp_valid | output | 1 | Short packet report valid |
| sp_vc | output | 2 | Short packet virtual channel |
| sp_dt | output | 6 | Short packet data type |
| sp_value | output | 16 | Short packet data field |
| cs_valid | output | 1 | Checksum report valid |
| cs_value | output | 16 | Received payload checksum |

## Verification
A wrong byte counter shows up within one beat, as a misplaced `st_last`, a wrong keep mask or a checksum built from payload bytes. A state machine stuck in the discard state swallows the next header, so that packet's beats or report never appear. A missed termination shows up one cycle after the trigger, either as a normal data beat where an empty closing beat was due or as a checksum report that should not exist. Flag errors appear on the closing beat itself, as an abort flag on a video type, a missing abort flag on embedded data, or a missing first marker.

// File: rtl/cpp_pkg.sv
package cpp_pkg;
  localparam int WC_W = 16;
  localparam int VC_W = 2;
  localparam int DT_W = 6;
  localparam int CS_W = 16;

  localparam logic [DT_W-1:0] DT_NULL  = 6'h10;
  localparam logic [DT_W-1:0] DT_BLANK = 6'h11;
  localparam logic [DT_W-1:0] DT_EMBED = 6'h12;
  localparam logic [DT_W-1:0] DT_LONG_MIN = 6'h10;

  typedef enum logic [1:0] {
    PK_SHORT,
    PK_DROP,
    PK_LONG
  } pkt_kind_t;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_PAY,
    PS_DROP
  } pstate_t;
endpackage

// File: rtl/cpp_hdr_decode.sv
module cpp_hdr_decode
  import cpp_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [8*NB-1:0] word,
  output logic [VC_W-1:0] vc,
  output logic [DT_W-1:0] dt,
  output logic [WC_W-1:0] wc,
  output pkt_kind_t       kind
);
  // byte 0: channel and type, bytes 1..2: count low then high, byte 3 unused
  assign dt = word[DT_W-1:0];
  assign vc = word[DT_W+VC_W-1:DT_W];
  assign wc = word[8+WC_W-1:8];

  always_comb begin
    if (dt < DT_LONG_MIN)                      kind = PK_SHORT;
    else if (dt == DT_NULL || dt == DT_BLANK)  kind = PK_DROP;
    else                                       kind = PK_LONG;
  end
endmodule

// File: rtl/cpp_lane_map.sv
module cpp_lane_map
  import cpp_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic [WC_W+1:0] cnt,
  input  logic [WC_W-1:0] wc,
  output logic [NB-1:0]   keep,
  output logic            has_end,
  output logic [NB-1:0]   lo_hit,
  output logic [NB-1:0]   hi_hit
);
  localparam int CNT_W = WC_W + 2;

  logic [CNT_W-1:0] wc_ext;
  logic [CNT_W-1:0] end_pos;
  logic [CNT_W-1:0] hi_pos;
  logic [NB-1:0]    end_hit;

  assign wc_ext  = {2'b00, wc};
  assign end_pos = wc_ext - CNT_W'(1);
  assign hi_pos  = wc_ext + CNT_W'(1);

  for (genvar j = 0; j < NB; j++) begin : g_lane
    logic [CNT_W-1:0] idx;
    assign idx        = cnt + CNT_W'(j);
    assign keep[j]    = idx < wc_ext;
    assign end_hit[j] = (wc != '0) && (idx == end_pos);
    assign lo_hit[j]  = idx == wc_ext;
    assign hi_hit[j]  = idx == hi_pos;
  end

  assign has_end = |end_hit;
endmodule

// File: rtl/csi_pkt_parser.sv
module csi_pkt_parser
  import cpp_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              soft_rst,
  input  logic              lb_full,
  input  logic              in_valid,
  input  logic [8*NB-1:0]   in_data,
  input  logic              in_last,
  output logic              st_valid,
  output logic [8*NB-1:0]   st_data,
  output logic [NB-1:0]     st_keep,
  output logic              st_first,
  output logic              st_last,
  output logic              st_abort,
  output logic [VC_W-1:0]   st_vc,
  output logic [DT_W-1:0]   st_dt,
  output logic              sp_valid,
  output logic [VC_W-1:0]   sp_vc,
  output logic [DT_W-1:0]   sp_dt,
  output logic [WC_W-1:0]   sp_value,
  output logic              cs_valid,
  output logic [CS_W-1:0]   cs_value
);
  localparam int DW    = 8 * NB;
  localparam int CNT_W = WC_W + 2;

  pstate_t          state;
  logic [CNT_W-1:0] cnt_q;
  logic [WC_W-1:0]  wc_q;
  logic [VC_W-1:0]  vc_q;
  logic [DT_W-1:0]  dt_q;
  logic             first_pend;
  logic             pay_open;
  logic [7:0]       cs_lo_q;

  logic [VC_W-1:0]  h_vc;
  logic [DT_W-1:0]  h_dt;
  logic [WC_W-1:0]  h_wc;
  pkt_kind_t        h_kind;

  logic [NB-1:0]    lane_keep;
  logic             lane_end;
  logic [NB-1:0]    lo_hit;
  logic [NB-1:0]    hi_hit;
  logic [7:0]       lo_byte;
  logic [7:0]       hi_byte;
  logic [DW-1:0]    masked;
  logic             halt;
  logic             is_embed;

  cpp_hdr_decode #(.NB(NB)) u_hdr (
    .word (in_data),
    .vc   (h_vc),
    .dt   (h_dt),
    .wc   (h_wc),
    .kind (h_kind)
  );

  cpp_lane_map #(.NB(NB)) u_map (
    .cnt     (cnt_q),
    .wc      (wc_q),
    .keep    (lane_keep),
    .has_end (lane_end),
    .lo_hit  (lo_hit),
    .hi_hit  (hi_hit)
  );

  for (genvar j = 0; j < NB; j++) begin : g_mask
    assign masked[8*j +: 8] = lane_keep[j] ? in_data[8*j +: 8] : 8'h00;
  end

  always_comb begin
    lo_byte = 8'h00;
    hi_byte = 8'h00;
    for (int j = 0; j < NB; j++) begin
      if (lo_hit[j]) lo_byte = in_data[8*j +: 8];
      if (hi_hit[j]) hi_byte = in_data[8*j +: 8];
    end
  end

  assign halt     = soft_rst || !enable || lb_full;
  assign is_embed = dt_q == DT_EMBED;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= PS_IDLE;
      cnt_q      <= '0;
      wc_q       <= '0;
      vc_q       <= '0;
      dt_q       <= '0;
      first_pend <= 1'b0;
      pay_open   <= 1'b0;
      cs_lo_q    <= '0;
      st_valid   <= 1'b0;
      st_data    <= '0;
      st_keep    <= '0;
      st_first   <= 1'b0;
      st_last    <= 1'b0;
      st_abort   <= 1'b0;
      st_vc      <= '0;
      st_dt      <= '0;
      sp_valid   <= 1'b0;
      sp_vc      <= '0;
      sp_dt      <= '0;
      sp_value   <= '0;
      cs_valid   <= 1'b0;
      cs_value   <= '0;
    end else begin
      st_valid <= 1'b0;
      sp_valid <= 1'b0;
      cs_valid <= 1'b0;
      unique case (state)
        PS_IDLE: begin
          if (in_valid) begin
            if (!enable || soft_rst) begin
              if (!in_last) state <= PS_DROP;
            end else begin
              unique case (h_kind)
                PK_SHORT: begin
                  sp_valid <= 1'b1;
                  sp_vc    <= h_vc;
                  sp_dt    <= h_dt;
                  sp_value <= h_wc;
                  if (!in_last) state <= PS_DROP;
                end
                PK_DROP: begin
                  if (!in_last) state <= PS_DROP;
                end
                default: begin
                  vc_q       <= h_vc;
                  dt_q       <= h_dt;
                  wc_q       <= h_wc;
                  cnt_q      <= '0;
                  first_pend <= 1'b1;
                  pay_open   <= h_wc != '0;
                  if (!in_last) state <= PS_PAY;
                end
              endcase
            end
          end
        end

        PS_PAY: begin
          if (halt) begin
            if (pay_open) begin
              st_valid <= 1'b1;
              st_data  <= '0;
              st_keep  <= '0;
              st_first <= first_pend;
              st_last  <= 1'b1;
              st_abort <= is_embed;
              st_vc    <= vc_q;
              st_dt    <= dt_q;
            end
            pay_open <= 1'b0;
            state    <= (in_valid && in_last) ? PS_IDLE : PS_DROP;
          end else if (in_valid) begin
            if (|lane_keep) begin
              st_valid   <= 1'b1;
              st_data    <= masked;
              st_keep    <= lane_keep;
              st_first   <= first_pend;
              st_vc      <= vc_q;
              st_dt      <= dt_q;
              first_pend <= 1'b0;
              // a burst that ends early closes the line as a termination
              if (in_last && !lane_end) begin
                st_last  <= 1'b1;
                st_abort <= is_embed;
              end else begin
                st_last  <= lane_end;
                st_abort <= 1'b0;
              end
            end
            if (lane_end) pay_open <= 1'b0;
            if (|lo_hit) cs_lo_q <= lo_byte;
            if (|hi_hit) begin
              cs_valid <= 1'b1;
              cs_value <= {hi_byte, (|lo_hit) ? lo_byte : cs_lo_q};
            end
            cnt_q <= cnt_q + CNT_W'(NB);
            if (|hi_hit) begin
              state <= in_last ? PS_IDLE : PS_DROP;
            end else if (in_last) begin
              pay_open <= 1'b0;
              state    <= PS_IDLE;
            end
          end
        end

        default: begin
          if (in_valid && in_last) state <= PS_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpp_checker.sv
module cpp_checker
  import cpp_pkg::*;
#(
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            st_valid,
  input logic [NB-1:0]   st_keep,
  input logic            st_first,
  input logic            st_last,
  input logic            st_abort,
  input logic [DT_W-1:0] st_dt,
  input logic            sp_valid,
  input logic [DT_W-1:0] sp_dt,
  input logic            cs_valid
);
  logic in_pkt;

  always_ff @(posedge clk) begin
    if (rst)           in_pkt <= 1'b0;
    else if (st_valid) in_pkt <= !st_last;
  end

  // R3: beats inside a packet are full, masks are contiguous from lane 0
  assert_full_keep_R3: assert property (@(posedge clk) disable iff (rst)
    st_valid && !st_last |-> &st_keep);
  assert_keep_contig_R3: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> ((st_keep & (st_keep + NB'(1))) == '0));
  // R3: a beat outside an open packet must start one, and only there
  assert_first_opens_R3: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> (st_first == !in_pkt));
  // R8: abort flag only on a closing beat of embedded data
  assert_abort_embed_R8: assert property (@(posedge clk) disable iff (rst)
    st_abort && st_valid |-> st_last && st_dt == DT_EMBED);
  // R8: an empty beat is always a closing beat
  assert_empty_closes_R8: assert property (@(posedge clk) disable iff (rst)
    st_valid && st_keep == '0 |-> st_last);
  // R2: short reports only carry short types and never share a cycle with a beat
  assert_short_type_R2: assert property (@(posedge clk) disable iff (rst)
    sp_valid |-> sp_dt < DT_LONG_MIN && !st_valid);
  // R5: the checksum report never coincides with a short report
  assert_cs_alone_R5: assert property (@(posedge clk) disable iff (rst)
    cs_valid |-> !sp_valid);
  // R12: outputs quiet right after reset
  assert_reset_quiet_R12: assert property (@(posedge clk)
    $past(rst) |-> !st_valid && !sp_valid && !cs_valid);
endmodule

bind csi_pkt_parser cpp_checker #(.NB(NB)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .st_valid (st_valid),
  .st_keep  (st_keep),
  .st_first (st_first),
  .st_last  (st_last),
  .st_abort (st_abort),
  .st_dt    (st_dt),
  .sp_valid (sp_valid),
  .sp_dt    (sp_dt),
  .cs_valid (cs_valid)
);

// File: tb/sim_csi_pkt_parser.sv
module sim_csi_pkt_parser;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int BW = DW + NB + 3 + 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst = 1'b1, enable = 1'b1, soft_rst = 1'b0, lb_full = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic st_valid, st_first, st_last, st_abort, sp_valid, cs_valid;
  logic [DW-1:0] st_data;
  logic [NB-1:0] st_keep;
  logic [1:0] st_vc, sp_vc;
  logic [5:0] st_dt, sp_dt;
  logic [15:0] sp_value, cs_value;

  csi_pkt_parser #(.NB(NB)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst), .lb_full(lb_full),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .st_valid(st_valid), .st_data(st_data), .st_keep(st_keep), .st_first(st_first),
    .st_last(st_last), .st_abort(st_abort), .st_vc(st_vc), .st_dt(st_dt),
    .sp_valid(sp_valid), .sp_vc(sp_vc), .sp_dt(sp_dt), .sp_value(sp_value),
    .cs_valid(cs_valid), .cs_value(cs_value)
  );

  int checks = 0, fails = 0;
  logic [BW-1:0] got_st[$], exp_st[$];
  logic [23:0]   got_sp[$], exp_sp[$];
  logic [15:0]   got_cs[$], exp_cs[$];

  always @(negedge clk) if (!rst) begin
    if (st_valid) got_st.push_back({st_data, st_keep, st_first, st_last, st_abort, st_vc, st_dt});
    if (sp_valid) got_sp.push_back({sp_vc, sp_dt, sp_value});
    if (cs_valid) got_cs.push_back(cs_value);
  end

  function automatic logic [BW-1:0] mk(logic [DW-1:0] d, logic [NB-1:0] k, logic f, logic l,
                                       logic a, logic [1:0] vc, logic [5:0] dt);
    return {d, k, f, l, a, vc, dt};
  endfunction

  task automatic check(input bit ok, input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: -1 none, 0 line buffer full, 1 disable, 2 soft reset
  task automatic drive(input logic [DW-1:0] d, input logic last, input int kind);
    repeat ($urandom_range(0, 2)) begin @(posedge clk); #1; end
    in_valid = 1'b1; in_data = d; in_last = last;
    lb_full  = (kind == 0);
    enable   = (kind != 1);
    soft_rst = (kind == 2);
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; lb_full = 1'b0; enable = 1'b1; soft_rst = 1'b0;
  endtask

  task automatic cmp_all(input string req);
    repeat (4) @(posedge clk);
    #1;
    check(got_st.size() == exp_st.size(), {req, " beat count"}, BW'(got_st.size()), BW'(exp_st.size()));
    for (int i = 0; i < got_st.size() && i < exp_st.size(); i++)
      check(got_st[i] == exp_st[i], {req, " beat"}, got_st[i], exp_st[i]);
    check(got_sp.size() == exp_sp.size(), {req, " short count"}, BW'(got_sp.size()), BW'(exp_sp.size()));
    for (int i = 0; i < got_sp.size() && i < exp_sp.size(); i++)
      check(got_sp[i] == exp_sp[i], {req, " short"}, BW'(got_sp[i]), BW'(exp_sp[i]));
    check(got_cs.size() == exp_cs.size(), {req, " checksum count"}, BW'(got_cs.size()), BW'(exp_cs.size()));
    for (int i = 0; i < got_cs.size() && i < exp_cs.size(); i++)
      check(got_cs[i] == exp_cs[i], {req, " checksum"}, BW'(got_cs[i]), BW'(exp_cs[i]));
    got_st.delete(); exp_st.delete(); got_sp.delete(); exp_sp.delete();
    got_cs.delete(); exp_cs.delete();
  endtask

  task automatic send_short(input logic [1:0] vc, input logic [5:0] dt, input logic [15:0] val,
                            input int pad, input int hkind, input string req);
    drive({8'($urandom), val[15:8], val[7:0], vc, dt}, pad == 0, hkind);
    for (int p = 0; p < pad; p++) drive(DW'($urandom), p == pad - 1, -1);
    if (hkind < 0) exp_sp.push_back({vc, dt, val});
    cmp_all(req);
  endtask

  task automatic send_long(input logic [1:0] vc, input logic [5:0] dt, input int wc,
                           input int ab_w, input int kind, input string req);
    int nw, wcs;
    bit drop;
    logic [7:0] by[];
    nw   = (wc + 2 + NB - 1) / NB + int'($urandom_range(0, 1));
    wcs  = (wc + 1) / NB;
    drop = (dt == 6'h10 || dt == 6'h11);
    by   = new[nw * NB];
    foreach (by[i]) by[i] = 8'($urandom);
    drive({8'($urandom), 8'(wc >> 8), 8'(wc), vc, dt}, 1'b0, -1);
    for (int w = 0; w < nw; w++) begin
      logic [DW-1:0] wd;
      for (int j = 0; j < NB; j++) wd[8*j +: 8] = by[w*NB + j];
      drive(wd, w == nw - 1, (w == ab_w) ? kind : -1);
    end
    if (!drop) begin
      for (int w = 0; w < nw; w++) begin
        logic [DW-1:0] d;
        logic [NB-1:0] k;
        if (ab_w >= 0 && w == ab_w) begin
          if (w * NB < wc) exp_st.push_back(mk('0, '0, w == 0, 1'b1, dt == 6'h12, vc, dt));
          break;
        end
        d = '0; k = '0;
        for (int j = 0; j < NB; j++)
          if (w*NB + j < wc) begin k[j] = 1'b1; d[8*j +: 8] = by[w*NB + j]; end
        if (k != '0)
          exp_st.push_back(mk(d, k, w == 0, (w*NB <= wc - 1) && (wc - 1 <= w*NB + NB - 1), 1'b0, vc, dt));
      end
      if (ab_w < 0 || ab_w > wcs) exp_cs.push_back({by[wc + 1], by[wc]});
    end
    cmp_all(req);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check(!st_valid && !sp_valid && !cs_valid, "R12 reset outputs",
          BW'({st_valid, sp_valid, cs_valid}), '0);
    rst = 1'b0;
    @(negedge clk);
    check(!st_valid && !sp_valid && !cs_valid, "R12 after reset",
          BW'({st_valid, sp_valid, cs_valid}), '0);
    @(posedge clk); #1;

    send_short(2'd1, 6'h00, 16'h1234, 0, -1, "R2 frame start");
    send_short(2'd3, 6'h0F, 16'hBEEF, 2, -1, "R1 R2 padded short");
    send_long(2'd0, 6'h2A, 1, -1, 0, "R3 one byte");
    send_long(2'd2, 6'h2B, 4, -1, 0, "R3 R5 aligned");
    send_long(2'd1, 6'h24, 7, -1, 0, "R5 checksum split");
    send_long(2'd3, 6'h12, 0, -1, 0, "R4 empty long");
    send_long(2'd0, 6'h10, 9, -1, 0, "R6 null");
    send_long(2'd1, 6'h11, 5, -1, 0, "R6 blanking");
    send_short(2'd2, 6'h02, 16'h0042, 0, -1, "R6 next parsed");
    send_long(2'd1, 6'h12, 20, 1, 0, "R8 full embedded");
    send_long(2'd2, 6'h2A, 20, 2, 1, "R8 disable video");
    send_long(2'd0, 6'h12, 12, 0, 2, "R8 soft reset first");
    send_long(2'd3, 6'h1E, 16, 3, 0, "R9 drop tail");
    send_long(2'd3, 6'h12, 4, 1, 0, "R10 late trigger");
    send_short(2'd1, 6'h01, 16'h5555, 1, 1, "R11 disabled header");
    send_long(2'd2, 6'h2C, 8, -1, 0, "R9 R11 recovered");

    for (int n = 0; n < 150; n++) begin
      int r;
      logic [5:0] dt;
      int wc;
      r  = int'($urandom_range(0, 9));
      wc = int'($urandom_range(0, 40));
      dt = ($urandom_range(0, 2) == 0) ? 6'h12 : 6'($urandom_range(6'h13, 6'h3F));
      if (r < 3)
        send_short(2'($urandom), 6'($urandom_range(0, 15)), 16'($urandom), int'($urandom_range(0, 1)), -1, "R7 short mix");
      else if (r == 3)
        send_long(2'($urandom), 6'($urandom_range(16, 17)), wc, -1, 0, "R6 drop mix");
      else if (r < 6)
        send_long(2'($urandom), dt, wc, int'($urandom_range(0, (wc + 2) / NB + 1)),
                  int'($urandom_range(0, 2)), "R8 R9 abort mix");
      else
        send_long(2'($urandom), dt, wc, -1, 0, "R3 R7 long mix");
    end
    finish_run();
  end
endmodule